// File: doc/BRIEF.md
# Regulator Enable and Start-Up Sequencer

This block is the digital control for an on-chip linear regulator that biases a downstream switching converter. It reads a three-level decode of the regulator-enable pin, a supply-above-lockout flag, the switcher enable, two comparator flags on the regulator output and a tick that marks each switching cycle. From these it turns the regulator on and off and grants or withdraws permission for the switcher to run. During start-up it also picks one of three current-limit steps, based on how far the output has risen.

Two state machines do the work. The regulator machine has four states. `RS_OFF` is idle. `RS_SOFT` is the lowest limit, about 65 mA. `RS_RAMP` is the middle limit, about 115 mA. `RS_FULL` is the highest limit, about 200 mA. Its transitions are:
- start: `RS_OFF` to `RS_SOFT`
- ramp: `RS_SOFT` to `RS_RAMP`
- full: `RS_SOFT` or `RS_RAMP` to `RS_FULL`
- shutdown: any state to `RS_OFF`

The switcher gate machine has three states: `GS_FOLLOW`, `GS_GRACE` and `GS_BLOCK`. Its transitions are:
- enter-grace: `GS_FOLLOW` to `GS_GRACE`, when a middle-band level appears
- expire: `GS_GRACE` to `GS_BLOCK`, when the middle band outlasts the allowed number of ticks
- release: `GS_GRACE` or `GS_BLOCK` back to `GS_FOLLOW`, when the level leaves the middle band

Because of the gate machine, a pin driven by logic can pass through the middle band on its way from high to low without stopping the switcher.

Top module: `ldo_seq`

## Requirements
- R1: While `rst_n` is low, `ldo_on` is 0 and `ilim_code` is 00. The gate is in `GS_FOLLOW`, so `sw_allow` equals `sw_en`.
- R2: From the off state, `ldo_on` rises after a clock edge that samples `enl_lvl` = 10 (high) together with `vin_ok` = 1. A middle-band level, or a high level with `vin_ok` = 0, leaves the regulator off.
- R3: After a clock edge that samples `enl_lvl` = 00 (low), `ldo_on` is 0 and `ilim_code` is 00. This holds from any state.
- R4: The current-limit code is 00 (lowest step) in `RS_SOFT`, 01 (middle step) in `RS_RAMP` and 10 (highest step) in `RS_FULL`. 11 never appears. A sampled `vout_at_90` moves `RS_SOFT` or `RS_RAMP` to `RS_FULL`. Otherwise a sampled `vout_gt_low` moves `RS_SOFT` to `RS_RAMP`.
- R5: Within one start-up attempt the code never steps back, even if the output flags fall again.
- R6: Every new start from the off state begins at code 00, whatever the output flags show in the starting cycle.
- R7: Once the regulator is on, `enl_lvl` = 01 (middle band) keeps it on. The code 11 is decoded as middle band.
- R8: When the gate is not blocked, `sw_allow` equals `sw_en` in the same cycle. This holds for low and high levels alike.
- R9: After the middle band is first sampled, the block counts each `sw_tick` sampled while the level stays in the middle band. `sw_allow` keeps following `sw_en` through the first two counted ticks. It goes to 0 after the edge that samples the third.
- R10: An edge that samples a level outside the middle band clears the tick count and returns the gate to `GS_FOLLOW`. After that edge, `sw_allow` equals `sw_en` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enl_lvl | input | 2 | Regulator-enable level: 00 low, 01 middle band, 10 high, 11 treated as middle band |
| vin_ok | input | 1 | Input supply is above its lockout level |
| sw_en | input | 1 | Switcher enable |
| vout_gt_low | input | 1 | Regulator output is above 0.75 V |
| vout_at_90 | input | 1 | Regulator output has reached 90 % of its final value |
| sw_tick | input | 1 | One-cycle pulse per switching cycle |
| ldo_on | output | 1 | Regulator enabled |
| sw_allow | output | 1 | Switcher permitted to run |
| ilim_code | output | 2 | Current-limit step: 00 low, 01 middle, 10 high |

## Verification
The assertions check on every cycle the rules that hold from one cycle to the next:
- a low level always ends in the off state with code 00;
- there is no start without a high level and a good supply;
- the code never moves backward;
- the gate never blocks without a preceding middle-band sample.

Only the bench scenarios can show the exact counts and their effect on outputs:
- the third middle-band tick is the one that blocks;
- a level excursion out of the middle band restarts the count;
- a start with the 90 % flag already set still passes through the lowest step first.

// File: rtl/ldo_seq_pkg.sv
package ldo_seq_pkg;

    localparam int ILIM_W = 2;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_HIGH = 2'b10;

    localparam logic [ILIM_W-1:0] ILIM_SOFT = 2'b00;
    localparam logic [ILIM_W-1:0] ILIM_RAMP = 2'b01;
    localparam logic [ILIM_W-1:0] ILIM_FULL = 2'b10;

    typedef enum logic [1:0] {
        RS_OFF  = 2'd0,
        RS_SOFT = 2'd1,
        RS_RAMP = 2'd2,
        RS_FULL = 2'd3
    } reg_state_e;

    typedef enum logic [1:0] {
        GS_FOLLOW = 2'd0,
        GS_GRACE  = 2'd1,
        GS_BLOCK  = 2'd2
    } gate_state_e;

endpackage

// File: rtl/ldo_lvl_decode.sv
module ldo_lvl_decode
    import ldo_seq_pkg::*;
(
    input  logic [1:0] enl_lvl,
    output logic       lvl_low,
    output logic       lvl_mid,
    output logic       lvl_high
);

    // 11 is not a legal comparator result; treat it as the safe middle band
    always_comb begin
        lvl_low  = 1'b0;
        lvl_mid  = 1'b0;
        lvl_high = 1'b0;
        unique case (enl_lvl)
            LVL_LOW:  lvl_low  = 1'b1;
            LVL_HIGH: lvl_high = 1'b1;
            default:  lvl_mid  = 1'b1;
        endcase
    end

    always_comb begin
        assert ($onehot({lvl_low, lvl_mid, lvl_high}))
            else $error("level decode not one-hot"); // R7
    end

endmodule

// File: rtl/ldo_stage_fsm.sv
module ldo_stage_fsm
    import ldo_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_low,
    input  logic              lvl_high,
    input  logic              vin_ok,
    input  logic              vout_gt_low,
    input  logic              vout_at_90,
    output logic              ldo_on,
    output logic [ILIM_W-1:0] ilim_code
);

    reg_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_OFF: begin
                // start: only a high level with a good supply
                if (lvl_high && vin_ok) state_d = RS_SOFT;
            end
            RS_SOFT: begin
                if (lvl_low)          state_d = RS_OFF;
                else if (vout_at_90)  state_d = RS_FULL;
                else if (vout_gt_low) state_d = RS_RAMP;
            end
            RS_RAMP: begin
                if (lvl_low)         state_d = RS_OFF;
                else if (vout_at_90) state_d = RS_FULL;
            end
            RS_FULL: begin
                if (lvl_low) state_d = RS_OFF;
            end
            default: state_d = RS_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_OFF;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        ldo_on    = 1'b1;
        ilim_code = ILIM_SOFT;
        unique case (state_q)
            RS_OFF:  ldo_on    = 1'b0;
            RS_SOFT: ilim_code = ILIM_SOFT;
            RS_RAMP: ilim_code = ILIM_RAMP;
            RS_FULL: ilim_code = ILIM_FULL;
            default: ldo_on    = 1'b0;
        endcase
    end

    AST_START_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldo_on && !(lvl_high && vin_ok)) |=> !ldo_on); // R2

    AST_LOW_SHUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_low |=> (!ldo_on && ilim_code == ILIM_SOFT)); // R3

    AST_ILIM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_code != 2'b11); // R4

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_code == ILIM_FULL && !lvl_low) |=> ilim_code == ILIM_FULL); // R5

    AST_RAMP_NO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_code == ILIM_RAMP && !lvl_low) |=> ilim_code != ILIM_SOFT); // R5

    AST_FRESH_START_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        !ldo_on |=> ilim_code == ILIM_SOFT); // R6

    AST_ON_UNLESS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ldo_on && !lvl_low) |=> ldo_on); // R7

endmodule

// File: rtl/ldo_sw_gate.sv
module ldo_sw_gate
    import ldo_seq_pkg::*;
#(
    parameter int GRACE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_mid,
    input  logic sw_en,
    input  logic sw_tick,
    output logic sw_allow
);

    localparam int CNT_W = $clog2(GRACE_TICKS + 2);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(GRACE_TICKS);

    gate_state_e      gate_q, gate_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state logic
    always_comb begin
        gate_d = gate_q;
        cnt_d  = cnt_q;
        unique case (gate_q)
            GS_FOLLOW: begin
                if (lvl_mid) begin
                    gate_d = GS_GRACE;
                    cnt_d  = '0;
                end
            end
            GS_GRACE: begin
                if (!lvl_mid) begin
                    gate_d = GS_FOLLOW;
                    cnt_d  = '0;
                end else if (sw_tick) begin
                    if (cnt_q == CNT_LIMIT) begin
                        gate_d = GS_BLOCK;
                        cnt_d  = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            GS_BLOCK: begin
                if (!lvl_mid) gate_d = GS_FOLLOW;
            end
            default: begin
                gate_d = GS_FOLLOW;
                cnt_d  = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= GS_FOLLOW;
            cnt_q  <= '0;
        end else begin
            gate_q <= gate_d;
            cnt_q  <= cnt_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (gate_q)
            GS_BLOCK: sw_allow = 1'b0;
            default:  sw_allow = sw_en;
        endcase
    end

    AST_BLOCK_AFTER_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !sw_allow) |-> $past(lvl_mid)); // R9

    AST_NO_TICK_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q == GS_GRACE && !sw_tick) |=> gate_q != GS_BLOCK); // R9

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LIMIT); // R9

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_mid |=> (sw_allow == sw_en)); // R10

endmodule

// File: rtl/ldo_seq.sv
module ldo_seq
    import ldo_seq_pkg::*;
#(
    parameter int GRACE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        enl_lvl,
    input  logic              vin_ok,
    input  logic              sw_en,
    input  logic              vout_gt_low,
    input  logic              vout_at_90,
    input  logic              sw_tick,
    output logic              ldo_on,
    output logic              sw_allow,
    output logic [ILIM_W-1:0] ilim_code
);

    logic lvl_low, lvl_mid, lvl_high;

    ldo_lvl_decode u_decode (
        .enl_lvl  (enl_lvl),
        .lvl_low  (lvl_low),
        .lvl_mid  (lvl_mid),
        .lvl_high (lvl_high)
    );

    ldo_stage_fsm u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_low     (lvl_low),
        .lvl_high    (lvl_high),
        .vin_ok      (vin_ok),
        .vout_gt_low (vout_gt_low),
        .vout_at_90  (vout_at_90),
        .ldo_on      (ldo_on),
        .ilim_code   (ilim_code)
    );

    ldo_sw_gate #(
        .GRACE_TICKS (GRACE_TICKS)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_mid  (lvl_mid),
        .sw_en    (sw_en),
        .sw_tick  (sw_tick),
        .sw_allow (sw_allow)
    );

    AST_LDO_OFF_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> (!ldo_on && ilim_code == ILIM_SOFT)); // R1

endmodule

// File: tb/ldo_seq_test.sv
module ldo_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] enl_lvl = 2'b00;
    logic       vin_ok = 1'b0;
    logic       sw_en = 1'b0;
    logic       vout_gt_low = 1'b0;
    logic       vout_at_90 = 1'b0;
    logic       sw_tick = 1'b0;
    logic       ldo_on;
    logic       sw_allow;
    logic [1:0] ilim_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    ldo_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enl_lvl     (enl_lvl),
        .vin_ok      (vin_ok),
        .sw_en       (sw_en),
        .vout_gt_low (vout_gt_low),
        .vout_at_90  (vout_at_90),
        .sw_tick     (sw_tick),
        .ldo_on      (ldo_on),
        .sw_allow    (sw_allow),
        .ilim_code   (ilim_code)
    );

    // Driver: apply inputs at the falling edge, queue the expectation for the next rising edge
    task automatic step(input logic [1:0] lv, input logic vin, input logic en,
                        input logic g75, input logic g90, input logic tk,
                        input logic e_on, input logic e_sw, input logic [1:0] e_il,
                        input string tag);
        @(negedge clk);
        enl_lvl     = lv;
        vin_ok      = vin;
        sw_en       = en;
        vout_gt_low = g75;
        vout_at_90  = g90;
        sw_tick     = tk;
        exp_q.push_back({e_on, e_sw, e_il});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                logic [3:0] a;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {ldo_on, sw_allow, ilim_code};
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: on/sw/ilim actual %b/%b/%b expected %b/%b/%b",
                             t, a[3], a[2], a[1:0], e[3], e[2], e[1:0]);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    localparam logic [1:0] L = 2'b00;
    localparam logic [1:0] M = 2'b01;
    localparam logic [1:0] H = 2'b10;

    initial begin
        // R1: reset holds regulator off, switcher follows enable
        step(H, 1, 1, 0, 0, 0, 0, 1, 2'b00, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        exp_q.push_back(4'b0000);
        tag_q.push_back("R1 after reset");
        enl_lvl = L; vin_ok = 0; sw_en = 0;
        step(L, 0, 1, 0, 0, 0, 0, 1, 2'b00, "R8 low level follows en");
        step(M, 1, 0, 0, 0, 0, 0, 0, 2'b00, "R2 mid does not start");
        step(H, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R2 no vin no start");
        step(H, 1, 0, 0, 0, 0, 1, 0, 2'b00, "R2 start");
        step(H, 1, 1, 0, 0, 0, 1, 1, 2'b00, "R8 high level follows en");
        step(H, 1, 1, 1, 0, 0, 1, 1, 2'b01, "R4 ramp step");
        step(H, 1, 1, 0, 0, 0, 1, 1, 2'b01, "R5 ramp holds");
        step(H, 1, 1, 1, 1, 0, 1, 1, 2'b10, "R4 full step");
        step(H, 1, 1, 0, 0, 0, 1, 1, 2'b10, "R5 full holds");
        // R9: middle-band grace of two ticks
        step(M, 1, 1, 0, 0, 0, 1, 1, 2'b10, "R7 mid keeps on");
        step(M, 1, 1, 0, 0, 1, 1, 1, 2'b10, "R9 tick1");
        step(M, 1, 1, 0, 0, 0, 1, 1, 2'b10, "R9 no tick");
        step(M, 1, 1, 0, 0, 1, 1, 1, 2'b10, "R9 tick2");
        step(M, 1, 1, 0, 0, 1, 1, 0, 2'b10, "R9 tick3 blocks");
        step(2'b11, 1, 1, 0, 0, 0, 1, 0, 2'b10, "R7 code 11 as mid");
        step(H, 1, 1, 0, 0, 0, 1, 1, 2'b10, "R10 release");
        // R10: leaving the band restarts the count
        step(M, 1, 1, 0, 0, 1, 1, 1, 2'b10, "R10 enter grace");
        step(M, 1, 1, 0, 0, 1, 1, 1, 2'b10, "R10 tick1");
        step(H, 1, 1, 0, 0, 0, 1, 1, 2'b10, "R10 excursion");
        step(M, 1, 1, 0, 0, 1, 1, 1, 2'b10, "R10 re-enter");
        step(M, 1, 1, 0, 0, 1, 1, 1, 2'b10, "R10 tick1 again");
        step(M, 1, 1, 0, 0, 1, 1, 1, 2'b10, "R10 count restarted");
        step(M, 1, 1, 0, 0, 1, 1, 0, 2'b10, "R9 block again");
        step(L, 0, 1, 0, 0, 0, 0, 1, 2'b00, "R3 low shuts off");
        step(L, 1, 0, 0, 0, 0, 0, 0, 2'b00, "R8 low level en off");
        step(H, 1, 1, 0, 1, 0, 1, 1, 2'b00, "R6 fresh start soft");
        step(H, 1, 1, 0, 1, 0, 1, 1, 2'b10, "R4 soft to full");
        step(L, 1, 1, 0, 0, 0, 0, 1, 2'b00, "R3 off from full");
        step(H, 1, 1, 0, 0, 0, 1, 1, 2'b00, "R6 restart soft");
        step(H, 1, 0, 0, 0, 0, 1, 0, 2'b00, "R8 en drop");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule